// File: doc/BRIEF.md
# Relative Branch Decision Unit

This block settles the outcome of a relative control transfer for a processor sequencer. A request supplies the status flags, the current word program counter and one of two kinds of instruction. A conditional branch picks one status bit by a 3-bit index and compares it with a polarity bit, and its offset is a short signed field. An unconditional relative jump always transfers and carries a wider signed offset. One cycle after the request, the unit reports whether control moves, the next program counter in word units and how many cycles the instruction costs.

The unit does not derive any flag. The flag vector comes in already formed, with bit 0 carry, bit 1 zero, bit 2 negative, bit 3 overflow, bit 4 signed-test (negative XOR overflow), bit 5 half carry, bit 6 transfer and bit 7 interrupt enable. Signed less-than is therefore index 4 tested for set, and signed greater-or-equal is index 4 tested for clear. Unsigned lower is index 0 set and same-or-higher is index 0 clear. Strict greater-than tests are formed by the compiler, which swaps the compare operands, so no compound condition is needed here.

Top module: `br_eval_unit`

## Requirements
- R1: `res_valid` is high exactly in the cycle after a cycle with `req_valid` high. Reset clears `res_valid` and `res_taken`, sets `res_target` to 0 and sets `res_cycles` to 0.
- R2: For a conditional request (`req_jump`=0), `res_taken` is 1 exactly when `flags[flag_sel]` equals `test_set`.
- R3: A taken conditional branch gives `res_target` = `cur_pc` + 1 + sign-extended `br_off` (7-bit two's complement), which covers PC-63 to PC+64.
- R4: A conditional branch that is not taken gives `res_target` = `cur_pc` + 1.
- R5: A jump request (`req_jump`=1) is always taken, with `res_target` = `cur_pc` + 1 + sign-extended `jmp_off` (12-bit, -2048 to 2047). `flags`, `flag_sel`, `test_set` and `br_off` have no effect on it.
- R6: `res_cycles` is 2 (binary 10) when the result is taken and 1 (binary 01) when it is not taken.
- R7: Target arithmetic wraps modulo 2^PCW.
- R8: While `req_valid` is low, `res_taken`, `res_target` and `res_cycles` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_jump | input | 1 | 1: unconditional relative jump, 0: conditional branch |
| flags | input | 8 | Status flags, bit layout as described above |
| flag_sel | input | 3 | Index of the tested flag |
| test_set | input | 1 | 1: branch when the bit is set, 0: when it is clear |
| br_off | input | 7 | Conditional branch offset, two's complement |
| jmp_off | input | 12 | Jump offset, two's complement |
| cur_pc | input | PCW | Current word program counter |
| res_valid | output | 1 | Result valid |
| res_taken | output | 1 | Control transfers |
| res_target | output | PCW | Next program counter |
| res_cycles | output | 2 | Instruction cycle cost |

## Verification
On every cycle the assertions check the valid timing, the flag and polarity decision, the fall-through and taken target sums, the always-taken jump and the tie between cycle count and the taken bit. They also check that results hold between requests. Only the bench scenarios show the offset extremes at PC-63, PC+64, -2048 and +2047, and wrap-around at both ends of the address space. The bench scenarios also show that flag and short-offset inputs have no effect on a jump. All of these are checked against values the bench computes itself under many random flag and offset patterns.

// File: rtl/br_eval_pkg.sv
package br_eval_pkg;
  localparam int unsigned FLAG_W  = 8;
  localparam int unsigned SEL_W   = $clog2(FLAG_W);
  localparam int unsigned CYC_W   = 2;

  typedef logic [CYC_W-1:0] cyc_t;

  localparam cyc_t CYC_FALL  = cyc_t'(1);
  localparam cyc_t CYC_TAKEN = cyc_t'(2);
endpackage

// File: rtl/br_flag_test.sv
module br_flag_test
  import br_eval_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  input  logic [SEL_W-1:0]  flag_sel,
  input  logic              test_set,
  output logic              match
);
  logic picked;

  always_comb begin
    picked = flags[flag_sel];
    match  = ~(picked ^ test_set);
  end
endmodule

// File: rtl/br_target_add.sv
module br_target_add #(
  parameter int unsigned PCW  = 16,
  parameter int unsigned OFFW = 7
) (
  input  logic [PCW-1:0]  pc,
  input  logic [OFFW-1:0] off,
  input  logic            apply_off,
  output logic [PCW-1:0]  target
);
  logic [PCW-1:0] off_ext;
  logic [PCW-1:0] seq_pc;

  generate
    if (PCW > OFFW) begin : g_sext
      assign off_ext = {{(PCW-OFFW){off[OFFW-1]}}, off};
    end else begin : g_trunc
      assign off_ext = off[PCW-1:0];
    end
  endgenerate

  always_comb begin
    seq_pc = pc + PCW'(1);
    target = apply_off ? (seq_pc + off_ext) : seq_pc;
  end
endmodule

// File: rtl/br_eval_unit.sv
module br_eval_unit
  import br_eval_pkg::*;
#(
  parameter int unsigned PCW    = 16,
  parameter int unsigned BR_OFFW = 7,
  parameter int unsigned JMP_OFFW = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_jump,
  input  logic [FLAG_W-1:0]   flags,
  input  logic [SEL_W-1:0]    flag_sel,
  input  logic                test_set,
  input  logic [BR_OFFW-1:0]  br_off,
  input  logic [JMP_OFFW-1:0] jmp_off,
  input  logic [PCW-1:0]      cur_pc,
  output logic                res_valid,
  output logic                res_taken,
  output logic [PCW-1:0]      res_target,
  output logic [CYC_W-1:0]    res_cycles
);
  logic           cond_hit;
  logic [PCW-1:0] cond_tgt;
  logic [PCW-1:0] jump_tgt;

  logic           taken_d;
  logic [PCW-1:0] target_d;
  cyc_t           cycles_d;

  br_flag_test u_test (
    .flags    (flags),
    .flag_sel (flag_sel),
    .test_set (test_set),
    .match    (cond_hit)
  );

  br_target_add #(.PCW(PCW), .OFFW(BR_OFFW)) u_cond_add (
    .pc        (cur_pc),
    .off       (br_off),
    .apply_off (cond_hit),
    .target    (cond_tgt)
  );

  br_target_add #(.PCW(PCW), .OFFW(JMP_OFFW)) u_jump_add (
    .pc        (cur_pc),
    .off       (jmp_off),
    .apply_off (1'b1),
    .target    (jump_tgt)
  );

  // next-state
  always_comb begin
    taken_d  = req_jump | cond_hit;
    target_d = req_jump ? jump_tgt : cond_tgt;
    cycles_d = taken_d ? CYC_TAKEN : CYC_FALL;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_taken  <= 1'b0;
      res_target <= '0;
      res_cycles <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_taken  <= taken_d;
        res_target <= target_d;
        res_cycles <= cycles_d;
      end
    end
  end
endmodule

// File: rtl/br_eval_chk.sv
module br_eval_chk
  import br_eval_pkg::*;
#(
  parameter int unsigned PCW    = 16,
  parameter int unsigned BR_OFFW = 7,
  parameter int unsigned JMP_OFFW = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_jump,
  input logic [FLAG_W-1:0]   flags,
  input logic [SEL_W-1:0]    flag_sel,
  input logic                test_set,
  input logic [BR_OFFW-1:0]  br_off,
  input logic [JMP_OFFW-1:0] jmp_off,
  input logic [PCW-1:0]      cur_pc,
  input logic                res_valid,
  input logic                res_taken,
  input logic [PCW-1:0]      res_target,
  input logic [CYC_W-1:0]    res_cycles
);
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);
  p_flag_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_jump) |=> res_taken == ($past(flags[flag_sel]) == $past(test_set)));
  p_fall_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_jump) |=> (res_taken || res_target == $past(cur_pc) + PCW'(1)));
  p_cond_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_jump) |=> (!res_taken ||
      res_target == $past(cur_pc) + PCW'(1) + PCW'($signed($past(br_off)))));
  p_jump_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_jump) |=> (res_taken &&
      res_target == $past(cur_pc) + PCW'(1) + PCW'($signed($past(jmp_off)))));
  p_cycle_cost_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_cycles == (res_taken ? CYC_TAKEN : CYC_FALL));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(res_taken) && $stable(res_target) && $stable(res_cycles)));
endmodule

bind br_eval_unit br_eval_chk #(.PCW(PCW), .BR_OFFW(BR_OFFW), .JMP_OFFW(JMP_OFFW)) u_chk (.*);

// File: tb/tb_br_eval_unit.sv
module tb_br_eval_unit;
  localparam int PCW = 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            req_valid, req_jump, test_set;
  logic [7:0]      flags;
  logic [2:0]      flag_sel;
  logic [6:0]      br_off;
  logic [11:0]     jmp_off;
  logic [PCW-1:0]  cur_pc;
  logic            res_valid, res_taken;
  logic [PCW-1:0]  res_target;
  logic [1:0]      res_cycles;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  br_eval_unit #(.PCW(PCW)) dut (.*);

  function automatic bit exp_taken(bit jmp, logic [7:0] f, logic [2:0] s, bit pol);
    return jmp ? 1'b1 : (f[s] == pol);
  endfunction

  function automatic logic [PCW-1:0] exp_target(bit jmp, bit tk, logic [PCW-1:0] pc,
                                                logic [6:0] bo, logic [11:0] jo);
    int off;
    off = jmp ? int'($signed(jo)) : (tk ? int'($signed(bo)) : 0);
    return PCW'(int'(pc) + 1 + off);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic issue(bit jmp, logic [7:0] f, logic [2:0] s, bit pol,
                       logic [6:0] bo, logic [11:0] jo, logic [PCW-1:0] pc, string req);
    bit tk;
    req_valid = 1; req_jump = jmp; flags = f; flag_sel = s; test_set = pol;
    br_off = bo; jmp_off = jo; cur_pc = pc;
    tk = exp_taken(jmp, f, s, pol);
    @(negedge clk);
    req_valid = 0;
    check({req, " valid R1"}, 32'(res_valid), 32'd1);
    check({req, " taken"}, 32'(res_taken), 32'(tk));
    check({req, " target"}, 32'(res_target), 32'(exp_target(jmp, tk, pc, bo, jo)));
    check({req, " cycles R6"}, 32'(res_cycles), tk ? 32'd2 : 32'd1);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; req_valid = 0; req_jump = 0; flags = 0; flag_sel = 0;
    test_set = 0; br_off = 0; jmp_off = 0; cur_pc = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset valid", 32'(res_valid), 0);
    check("R1 reset taken", 32'(res_taken), 0);
    check("R1 reset target", 32'(res_target), 0);
    check("R1 reset cycles", 32'(res_cycles), 0);
    rst_n = 1;
    @(negedge clk);

    // R2: signed-less-than (bit 4 set) and unsigned-lower (bit 0)
    issue(0, 8'h10, 3'd4, 1, 7'd5, 12'd0, 16'h0100, "R2 S set taken");
    issue(0, 8'h10, 3'd4, 0, 7'd5, 12'd0, 16'h0100, "R4 S set pol clear");
    issue(0, 8'h01, 3'd0, 0, 7'd9, 12'd0, 16'h0200, "R4 C set same-or-higher");
    issue(0, 8'hFE, 3'd0, 0, 7'd9, 12'd0, 16'h0200, "R2 C clear taken");
    // R3 range ends
    issue(0, 8'h02, 3'd1, 1, 7'h40, 12'd0, 16'h1000, "R3 min -63");
    check("R3 PC-63", 32'(res_target), 32'h1000 - 63);
    issue(0, 8'h02, 3'd1, 1, 7'h3F, 12'd0, 16'h1000, "R3 max +64");
    check("R3 PC+64", 32'(res_target), 32'h1000 + 64);
    // R5 jump ends, flags ignored
    issue(1, 8'h00, 3'd2, 1, 7'h7F, 12'h800, 16'h3000, "R5 jump -2048");
    issue(1, 8'hFF, 3'd2, 0, 7'h40, 12'h7FF, 16'h3000, "R5 jump +2047");
    check("R5 flags ignored taken", 32'(res_taken), 1);
    // R7 wrap
    issue(0, 8'h00, 3'd7, 0, 7'd3, 12'd0, 16'hFFFF, "R7 wrap up");
    check("R7 wrapped", 32'(res_target), 32'd3);
    issue(0, 8'h80, 3'd7, 1, 7'h40, 12'd0, 16'h0000, "R7 wrap down");
    issue(1, 8'h00, 3'd0, 0, 7'd0, 12'h7FF, 16'hFF00, "R7 jump wrap");
    // R8 hold
    begin
      logic [PCW-1:0] t0;
      logic           k0;
      logic [1:0]     c0;
      t0 = res_target; k0 = res_taken; c0 = res_cycles;
      flags = 8'h00; flag_sel = 3'd3; test_set = 1; req_jump = 0;
      cur_pc = 16'h5555; br_off = 7'd1;
      repeat (2) @(negedge clk);
      check("R8 hold target", 32'(res_target), 32'(t0));
      check("R8 hold taken", 32'(res_taken), 32'(k0));
      check("R8 hold cycles", 32'(res_cycles), 32'(c0));
      check("R1 valid low idle", 32'(res_valid), 0);
    end
    // random
    for (int i = 0; i < 400; i++) begin
      issue(($urandom % 4) == 0, 8'($urandom), 3'($urandom), 1'($urandom),
            7'($urandom), 12'($urandom), 16'($urandom), "R2 R3 R5 random");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule